// File: doc/BRIEF.md
# Luma Undershoot Clamp

This block holds the luma signal above a selectable floor while active video is on screen. Each clock carries one sample: a signed luma value, a chroma value and an active-video flag. An interpolation-enable flag and a 2-bit limit code set whether the clamp acts and how deep the floor sits. The three floors are fixed depths below black level, given in IRE. With the default scale of 8 codes per IRE, and black at code 0, the floors are -88, -48 and -12.

The result is registered. Chroma and the active-video flag go through the same single register stage, so all three outputs stay aligned. Blanking and sync samples are never altered. When interpolation is off, or the code selects no limit, luma passes through unchanged. The limit code is sampled with the luma it applies to, so a new code acts on the very next sample and never part-way through one.

Top module: `luma_floor_clamp`

## Requirements
- R1: While reset is asserted, lumaOut, chromaOut and activeOut are all zero.
- R2: With limitSel = 00, lumaOut equals the luma sample from one cycle earlier, whatever its value.
- R3: With limitSel = 01, active video and interpolation on, a luma sample below -88 (-11 IRE at 8 codes per IRE) comes out as -88.
- R4: With limitSel = 10, active video and interpolation on, a luma sample below -48 (-6 IRE) comes out as -48.
- R5: With limitSel = 11, active video and interpolation on, a luma sample below -12 (-1.5 IRE) comes out as -12.
- R6: A luma sample at or above the selected floor comes out unchanged.
- R7: When activeIn is 0, luma comes out unchanged for every limit code.
- R8: When interpEn is 0, luma comes out unchanged for every limit code.
- R9: lumaOut, chromaOut and activeOut each show the input of the previous clock. Chroma and the active flag are never modified.
- R10: A limit code applies to the sample presented in the same cycle. A code that changes every cycle gives each sample its own floor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lumaIn | input | LUMA_W | Signed luma sample, 0 = black level |
| chromaIn | input | CHROMA_W | Chroma sample, carried through |
| activeIn | input | 1 | 1 = sample lies in active video |
| interpEn | input | 1 | 1 = interpolation enabled, clamp allowed |
| limitSel | input | 2 | Floor select: 00 off, 01 -11 IRE, 10 -6 IRE, 11 -1.5 IRE |
| lumaOut | output | LUMA_W | Limited luma, one cycle later |
| chromaOut | output | CHROMA_W | Chroma, one cycle later |
| activeOut | output | 1 | Active flag, one cycle later |

## Verification
The bench builds the block with the default parameters: 12-bit luma, 8-bit chroma and 8 codes per IRE. Those values are small enough to sweep every luma code against all sixteen combinations of limit code, active flag and interpolation flag. Every floor boundary is therefore hit exactly, from both sides. The limit code changes on every sample, which shows directly that each sample gets the code presented with it.

// File: rtl/luma_clamp_pkg.sv
package luma_clamp_pkg;
  typedef enum logic [1:0] {
    LIM_OFF     = 2'b00,
    LIM_DEEP    = 2'b01,
    LIM_MID     = 2'b10,
    LIM_SHALLOW = 2'b11
  } limitCode_e;

  // Strobes from control to datapath: clamp allowed plus one-hot floor pick.
  typedef struct packed {
    logic clampEn;
    logic pickDeep;
    logic pickMid;
    logic pickShallow;
  } clampCtrl_t;

  // Floor depths in half-IRE steps below black.
  localparam int DEEP_HALF_IRE    = 22;
  localparam int MID_HALF_IRE     = 12;
  localparam int SHALLOW_HALF_IRE = 3;
endpackage

// File: rtl/luma_clamp_ctrl.sv
module luma_clamp_ctrl
  import luma_clamp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       activeIn,
  input  logic       interpEn,
  input  logic [1:0] limitSel,
  output clampCtrl_t ctrl
);
  limitCode_e code;
  logic       gateOpen;

  assign code     = limitCode_e'(limitSel);
  assign gateOpen = activeIn && interpEn;

  always_comb begin
    ctrl = '0;
    if (gateOpen) begin
      unique case (code)
        LIM_DEEP:    ctrl.pickDeep    = 1'b1;
        LIM_MID:     ctrl.pickMid     = 1'b1;
        LIM_SHALLOW: ctrl.pickShallow = 1'b1;
        default:     ctrl.pickDeep    = 1'b0;
      endcase
    end
    ctrl.clampEn = ctrl.pickDeep | ctrl.pickMid | ctrl.pickShallow;
  end

  // R2: no floor is chosen when the code is off; at most one floor otherwise
  a_r2_off_no_pick: assert property (@(posedge clk) disable iff (!rstN)
    (limitSel == 2'b00) |-> !ctrl.clampEn);
  a_r10_single_floor: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.pickDeep, ctrl.pickMid, ctrl.pickShallow}));
  // R7 / R8: the gate closes outside active video or without interpolation
  a_r7_r8_gate: assert property (@(posedge clk) disable iff (!rstN)
    (!activeIn || !interpEn) |-> (ctrl == '0));
endmodule

// File: rtl/luma_clamp_datapath.sv
module luma_clamp_datapath
  import luma_clamp_pkg::*;
#(
  parameter int LUMA_W        = 12,
  parameter int CHROMA_W      = 8,
  parameter int CODES_PER_IRE = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  clampCtrl_t               ctrl,
  input  logic signed [LUMA_W-1:0] lumaIn,
  input  logic [CHROMA_W-1:0]      chromaIn,
  input  logic                     activeIn,
  output logic signed [LUMA_W-1:0] lumaOut,
  output logic [CHROMA_W-1:0]      chromaOut,
  output logic                     activeOut
);
  localparam int DEEP_INT    = -(DEEP_HALF_IRE * CODES_PER_IRE) / 2;
  localparam int MID_INT     = -(MID_HALF_IRE * CODES_PER_IRE) / 2;
  localparam int SHALLOW_INT = -(SHALLOW_HALF_IRE * CODES_PER_IRE) / 2;
  localparam logic signed [LUMA_W-1:0] FLOOR_DEEP    = LUMA_W'(DEEP_INT);
  localparam logic signed [LUMA_W-1:0] FLOOR_MID     = LUMA_W'(MID_INT);
  localparam logic signed [LUMA_W-1:0] FLOOR_SHALLOW = LUMA_W'(SHALLOW_INT);

  logic signed [LUMA_W-1:0] floorVal;
  logic                     belowFloor;
  logic signed [LUMA_W-1:0] lumaNext;

  always_comb begin
    floorVal = FLOOR_SHALLOW;
    if (ctrl.pickDeep)     floorVal = FLOOR_DEEP;
    else if (ctrl.pickMid) floorVal = FLOOR_MID;
  end

  assign belowFloor = lumaIn < floorVal;
  assign lumaNext   = (ctrl.clampEn && belowFloor) ? floorVal : lumaIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lumaOut   <= '0;
      chromaOut <= '0;
      activeOut <= 1'b0;
    end else begin
      lumaOut   <= lumaNext;
      chromaOut <= chromaIn;
      activeOut <= activeIn;
    end
  end

  // R6: anything at or above the floor leaves untouched
  a_r6_above_kept: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.clampEn && !belowFloor) |=> (lumaOut == $past(lumaIn)));
  // R3: the deep floor is never undercut
  a_r3_deep_floor: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.pickDeep |=> (lumaOut >= FLOOR_DEEP));
  // R4: the middle floor is never undercut
  a_r4_mid_floor: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.pickMid |=> (lumaOut >= FLOOR_MID));
  // R5: the shallow floor is never undercut
  a_r5_shallow_floor: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.pickShallow |=> (lumaOut >= FLOOR_SHALLOW));
  // R9: side channels are carried through one register untouched
  a_r9_side_delay: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (chromaOut == $past(chromaIn) && activeOut == $past(activeIn)));
endmodule

// File: rtl/luma_floor_clamp.sv
module luma_floor_clamp
  import luma_clamp_pkg::*;
#(
  parameter int LUMA_W        = 12,
  parameter int CHROMA_W      = 8,
  parameter int CODES_PER_IRE = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic signed [LUMA_W-1:0] lumaIn,
  input  logic [CHROMA_W-1:0]      chromaIn,
  input  logic                     activeIn,
  input  logic                     interpEn,
  input  logic [1:0]               limitSel,
  output logic signed [LUMA_W-1:0] lumaOut,
  output logic [CHROMA_W-1:0]      chromaOut,
  output logic                     activeOut
);
  clampCtrl_t ctrl;

  luma_clamp_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .activeIn (activeIn),
    .interpEn (interpEn),
    .limitSel (limitSel),
    .ctrl     (ctrl)
  );

  luma_clamp_datapath #(
    .LUMA_W        (LUMA_W),
    .CHROMA_W      (CHROMA_W),
    .CODES_PER_IRE (CODES_PER_IRE)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .lumaIn    (lumaIn),
    .chromaIn  (chromaIn),
    .activeIn  (activeIn),
    .lumaOut   (lumaOut),
    .chromaOut (chromaOut),
    .activeOut (activeOut)
  );

  // R7: blanking and sync samples are passed as they came
  a_r7_blank_pass: assert property (@(posedge clk) disable iff (!rstN)
    !activeIn |=> (lumaOut == $past(lumaIn)));
  // R8: without interpolation the luma is never altered
  a_r8_nointerp_pass: assert property (@(posedge clk) disable iff (!rstN)
    !interpEn |=> (lumaOut == $past(lumaIn)));
  // R2: code off passes luma through
  a_r2_off_pass: assert property (@(posedge clk) disable iff (!rstN)
    (limitSel == 2'b00) |=> (lumaOut == $past(lumaIn)));
endmodule

// File: tb/tb_luma_floor_clamp.sv
module tb_luma_floor_clamp;
  localparam int LW = 12;
  localparam int CW = 8;
  localparam int CPI = 8;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic signed [LW-1:0] lumaIn = '0;
  logic [CW-1:0]        chromaIn = '0;
  logic                 activeIn = 1'b0;
  logic                 interpEn = 1'b0;
  logic [1:0]           limitSel = 2'b00;
  logic signed [LW-1:0] lumaOut;
  logic [CW-1:0]        chromaOut;
  logic                 activeOut;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  luma_floor_clamp #(.LUMA_W(LW), .CHROMA_W(CW), .CODES_PER_IRE(CPI)) dut (
    .clk(clk), .rstN(rstN), .lumaIn(lumaIn), .chromaIn(chromaIn),
    .activeIn(activeIn), .interpEn(interpEn), .limitSel(limitSel),
    .lumaOut(lumaOut), .chromaOut(chromaOut), .activeOut(activeOut)
  );

  function automatic int floorOf(int code);
    case (code)
      1: return -(11 * CPI);
      2: return -(6 * CPI);
      3: return -(3 * CPI) / 2;
      default: return -100000;
    endcase
  endfunction

  task automatic checkVal(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit havePrev = 0;
    int expLuma = 0;
    int expChroma = 0;
    int expActive = 0;
    string prevTag = "";

    // R1: reset state
    repeat (3) @(negedge clk);
    checkVal("R1", int'(lumaOut), 0);
    checkVal("R1", int'(chromaOut), 0);
    checkVal("R1", int'(activeOut), 0);
    rstN = 1'b1;

    for (int v = -(1 << (LW - 1)); v < (1 << (LW - 1)); v++) begin
      for (int m = 0; m < 16; m++) begin
        int code;
        int fl;
        bit act;
        bit itp;
        string tag;
        @(negedge clk);
        if (havePrev) begin
          checkVal(prevTag, int'(lumaOut), expLuma);
          checkVal("R9", int'(chromaOut), expChroma);
          checkVal("R9", int'(activeOut), expActive);
        end
        code = m % 4;
        act  = m[2];
        itp  = m[3];
        fl   = floorOf(code);
        lumaIn   = LW'(v);
        chromaIn = CW'(v * 7 + m);
        activeIn = act;
        interpEn = itp;
        limitSel = 2'(code);
        expChroma = (v * 7 + m) & ((1 << CW) - 1);
        expActive = act;
        expLuma   = v;
        if (!act)           tag = "R7";
        else if (!itp)      tag = "R8";
        else if (code == 0) tag = "R2";
        else if (v < fl) begin
          expLuma = fl;
          tag = (code == 1) ? "R3 R10" : (code == 2) ? "R4 R10" : "R5 R10";
        end else            tag = "R6 R10";
        prevTag  = tag;
        havePrev = 1;
      end
    end
    @(negedge clk);
    checkVal(prevTag, int'(lumaOut), expLuma);
    checkVal("R9", int'(chromaOut), expChroma);
    checkVal("R9", int'(activeOut), expActive);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule